// File: doc/BRIEF.md
# Transfer Byte Counter with Address Tracker

This block keeps the books for a byte-oriented data path. Software loads a remaining byte count and a starting address one byte at a time through a small register port. The data path pulses a single completion strobe once for every byte that has actually crossed the bus. On each pulse the count steps down by one and the tracked address steps up by one in the same cycle. The tracked address therefore always points just past the last byte that truly finished, even when a fetch address elsewhere in the data path runs ahead.

Two status bits are kept. Done is a level that follows a zero count. Wrap is sticky: it is set when a strobe arrives while the count is already zero, so the count rolls over to all ones. It stays set until software clears it. A control write can also zero the count. The strobe is an event, not a data stream, so it has no ready. The block accepts one completion in every cycle and never applies back-pressure.

Register offsets with default parameters: count bytes at 0..2, address bytes at 4..7, control/status at 8. All other offsets are unmapped.

Top module: `tbc_xfer_tracker`

## Requirements
- R1: After reset the count and address are zero, done reads 1 and wrap reads 0.
- R2: The count and address are little-endian. A write to offset 0..2 sets only that count byte, and a write to offset 4..7 sets only that address byte, with offset 0 or 4 holding the least significant byte. Reads at these offsets return the current byte.
- R3: A completion strobe with no write in the same cycle lowers the count by one, modulo 2^24, from the next cycle on.
- R4: Each completion strobe raises the address by one, modulo 2^32, in the same cycle as the count step, unless an address byte is written in that cycle.
- R5: cnt_zero is 1 exactly when the count is zero. Bit 0 at offset 8 reads the same value.
- R6: A strobe that finds the count at zero leaves the count at 0xFFFFFF and sets wrap. Wrap then stays 1 and reads as bit 1 at offset 8.
- R7: Writing offset 8 with bit 1 set clears wrap. If a rollover happens in the same cycle, wrap stays set.
- R8: Writing offset 8 with bit 0 set forces the count to zero and blocks that cycle's count step. The address is not affected.
- R9: A write to a count byte in the same cycle as a strobe stores the written byte, keeps the other count bytes, and skips the decrement. A write to an address byte in the same cycle as a strobe does the same for the address.
- R10: Offsets 3 and 9..15 read as zero, and writes to them change neither value nor flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register byte offset for read and write |
| reg_wr | input | 1 | Write strobe for the byte at reg_addr |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| byte_done | input | 1 | One pulse per byte that completed on the bus |
| cnt_zero | output | 1 | Count is zero |
| cnt_wrap | output | 1 | Sticky count-rollover flag |

## Verification
The bench builds the block with its default widths: a three-byte count, a four-byte address and a four-bit offset. With these widths the count rollover can be reached in one strobe after a clear, and the full address carry can be reached by loading all ones. A behavioural model steps alongside the design on every clock. Directed cycles pile a strobe onto a byte load, a count clear or a wrap clear, to check which action wins. A long pseudo-random strobe pattern with rotating reads then checks lockstep stepping and byte carries.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  // control write bits at the control/status offset
  localparam int CTL_CLR_CNT  = 0;
  localparam int CTL_CLR_WRAP = 1;
  // status read bits at the same offset
  localparam int STS_DONE     = 0;
  localparam int STS_WRAP     = 1;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tbc_step_counter.sv
module tbc_step_counter
  import tbc_pkg::*;
#(
  parameter int NBYTES = 3,
  parameter bit DOWN   = 1'b1,
  localparam int W     = 8 * NBYTES,
  localparam int IW    = idx_width(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [7:0]    ld_data,
  input  logic          clr,
  input  logic          step,
  output logic [W-1:0]  value,
  output logic          roll
);
  logic [W-1:0] stepped;
  logic [W-1:0] base;
  logic [W-1:0] nxt;

  assign stepped = DOWN ? (value - W'(1)) : (value + W'(1));

  // a byte load holds the whole word for the cycle; clear beats step
  always_comb begin
    if (ld_en)     base = value;
    else if (clr)  base = '0;
    else if (step) base = stepped;
    else           base = value;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign nxt[8*g +: 8] = (ld_en && (ld_idx == IW'(g))) ? ld_data : base[8*g +: 8];

    AST_LANE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && (ld_idx == IW'(g))) |=> (value[8*g +: 8] == $past(ld_data))); // R2
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= nxt;
  end

  assign roll = step && !ld_en && !clr && (DOWN ? (value == '0) : (value == '1));

  AST_LOAD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && step) |=> ($countones(value ^ $past(value)) <= 8)); // R9
endmodule

// File: rtl/tbc_sticky_flag.sv
module tbc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q); // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q); // R6
endmodule

// File: rtl/tbc_xfer_tracker.sv
module tbc_xfer_tracker
  import tbc_pkg::*;
#(
  parameter int CNT_BYTES = 3,
  parameter int ADR_BYTES = 4,
  parameter int REG_AW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              byte_done,
  output logic              cnt_zero,
  output logic              cnt_wrap
);
  localparam int CW       = 8 * CNT_BYTES;
  localparam int AW       = 8 * ADR_BYTES;
  localparam int CIW      = idx_width(CNT_BYTES);
  localparam int AIW      = idx_width(ADR_BYTES);
  localparam int ADR_BASE = 1 << $clog2(CNT_BYTES);
  localparam int CTL_OFF  = ADR_BASE + (1 << $clog2(ADR_BYTES));

  logic [CW-1:0]     cnt_q;
  logic [AW-1:0]     adr_q;
  logic [REG_AW-1:0] adr_off;
  logic              cnt_hit, adr_hit, ctl_wr;
  logic              clr_cnt, clr_wrap, cnt_roll, adr_roll;

  // offset decode
  assign adr_off  = reg_addr - REG_AW'(ADR_BASE);
  assign cnt_hit  = reg_wr && (reg_addr < REG_AW'(CNT_BYTES));
  assign adr_hit  = reg_wr && (reg_addr >= REG_AW'(ADR_BASE)) && (adr_off < REG_AW'(ADR_BYTES));
  assign ctl_wr   = reg_wr && (reg_addr == REG_AW'(CTL_OFF));
  assign clr_cnt  = ctl_wr && reg_wdata[CTL_CLR_CNT];
  assign clr_wrap = ctl_wr && reg_wdata[CTL_CLR_WRAP];

  tbc_step_counter #(.NBYTES(CNT_BYTES), .DOWN(1'b1)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (cnt_hit),
    .ld_idx (reg_addr[CIW-1:0]),
    .ld_data(reg_wdata),
    .clr    (clr_cnt),
    .step   (byte_done),
    .value  (cnt_q),
    .roll   (cnt_roll)
  );

  tbc_step_counter #(.NBYTES(ADR_BYTES), .DOWN(1'b0)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (adr_hit),
    .ld_idx (adr_off[AIW-1:0]),
    .ld_data(reg_wdata),
    .clr    (1'b0),
    .step   (byte_done),
    .value  (adr_q),
    .roll   (adr_roll)
  );

  tbc_sticky_flag u_wrap (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (cnt_roll),
    .clr  (clr_wrap),
    .q    (cnt_wrap)
  );

  assign cnt_zero = (cnt_q == '0);

  // read mux
  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < CNT_BYTES; i++)
      if (reg_addr == REG_AW'(i)) reg_rdata = cnt_q[8*i +: 8];
    for (int j = 0; j < ADR_BYTES; j++)
      if (reg_addr == REG_AW'(ADR_BASE + j)) reg_rdata = adr_q[8*j +: 8];
    if (reg_addr == REG_AW'(CTL_OFF)) begin
      reg_rdata[STS_DONE] = cnt_zero;
      reg_rdata[STS_WRAP] = cnt_wrap;
    end
  end

  AST_LOCKSTEP_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && byte_done) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R3
  AST_LOCKSTEP_ADR: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && byte_done) |=> (adr_q == $past(adr_q) + AW'(1))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !byte_done) |=> ($stable(cnt_q) && $stable(adr_q))); // R10
  AST_CLEAR_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> (cnt_zero && !$past(adr_roll && 1'b0))); // R8
  AST_WRAP_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !reg_wr && cnt_zero) |=> (cnt_wrap && (cnt_q == '1))); // R6
endmodule

// File: tb/tb_tbc_xfer_tracker.sv
`timescale 1ns/1ps
module tb_tbc_xfer_tracker;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       byte_done;
  logic       cnt_zero;
  logic       cnt_wrap;

  always #5 clk = ~clk;

  tbc_xfer_tracker dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .byte_done(byte_done),
    .cnt_zero(cnt_zero), .cnt_wrap(cnt_wrap)
  );

  // behavioural reference state
  logic [23:0] m_cnt;
  logic [31:0] m_adr;
  logic        m_wrap;
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0: return m_cnt[7:0];
      4'd1: return m_cnt[15:8];
      4'd2: return m_cnt[23:16];
      4'd4: return m_adr[7:0];
      4'd5: return m_adr[15:8];
      4'd6: return m_adr[23:16];
      4'd7: return m_adr[31:24];
      4'd8: return {6'b0, m_wrap, (m_cnt == 24'd0)};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step(input logic [3:0] a, input bit w, input logic [7:0] d, input bit s);
    bit wrap_ev = 0;
    if (w && a <= 4'd2) m_cnt[8*a +: 8] = d;
    else if (w && a == 4'd8 && d[0]) m_cnt = 24'd0;
    else if (s) begin
      if (m_cnt == 24'd0) wrap_ev = 1;
      m_cnt = m_cnt - 24'd1;
    end
    if (w && a >= 4'd4 && a <= 4'd7) m_adr[8*(a-4) +: 8] = d;
    else if (s) m_adr = m_adr + 32'd1;
    if (wrap_ev) m_wrap = 1'b1;
    else if (w && a == 4'd8 && d[1]) m_wrap = 1'b0;
  endtask

  task automatic cyc(input logic [3:0] a, input bit w, input logic [7:0] d, input bit s,
                     input string tag = "R2 readback");
    reg_addr = a; reg_wr = w; reg_wdata = d; byte_done = s;
    @(posedge clk);
    model_step(a, w, d, s);
    @(negedge clk);
    chk(cnt_zero == (m_cnt == 24'd0), "R5 done level", {31'b0, cnt_zero}, {31'b0, (m_cnt == 24'd0)});
    chk(cnt_wrap == m_wrap, "R6 wrap flag", {31'b0, cnt_wrap}, {31'b0, m_wrap});
    chk(reg_rdata == exp_rd(a), tag, {24'b0, reg_rdata}, {24'b0, exp_rd(a)});
  endtask

  task automatic rd_lit(input logic [3:0] a, input logic [7:0] exp, input string tag);
    cyc(a, 1'b0, 8'h00, 1'b0, tag);
    chk(reg_rdata == exp, tag, {24'b0, reg_rdata}, {24'b0, exp});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned lcg = 32'h1234_5678;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 0; reg_wdata = '0; byte_done = 0;
    m_cnt = '0; m_adr = '0; m_wrap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_lit(4'd0, 8'h00, "R1 count lsb");
    rd_lit(4'd7, 8'h00, "R1 addr msb");
    rd_lit(4'd8, 8'h01, "R1 status");

    // R2 byte loads
    cyc(4'd0, 1, 8'h05, 0); cyc(4'd1, 1, 8'h00, 0); cyc(4'd2, 1, 8'h00, 0);
    cyc(4'd4, 1, 8'hFE, 0); cyc(4'd5, 1, 8'h00, 0); cyc(4'd6, 1, 8'h00, 0); cyc(4'd7, 1, 8'h10, 0);
    rd_lit(4'd0, 8'h05, "R2 count lsb");
    rd_lit(4'd7, 8'h10, "R2 addr msb");
    rd_lit(4'd4, 8'hFE, "R2 addr lsb");

    // R3 R4 five completions down to zero, address carries
    for (int i = 0; i < 5; i++) cyc(4'd8, 0, 8'h00, 1);
    rd_lit(4'd0, 8'h00, "R3 count reached zero");
    rd_lit(4'd4, 8'h03, "R4 addr lsb carry");
    rd_lit(4'd5, 8'h01, "R4 addr byte1 carry");
    rd_lit(4'd8, 8'h01, "R5 done at zero");

    // R6 rollover
    cyc(4'd8, 0, 8'h00, 1);
    rd_lit(4'd8, 8'h02, "R6 wrap set");
    rd_lit(4'd2, 8'hFF, "R6 count all ones");
    cyc(4'd0, 0, 8'h00, 0);
    rd_lit(4'd8, 8'h02, "R6 wrap sticky");

    // R7 clear wrap
    cyc(4'd8, 1, 8'h02, 0);
    rd_lit(4'd8, 8'h00, "R7 wrap cleared");

    // R8 clear count beats strobe, address still steps
    cyc(4'd8, 1, 8'h01, 1);
    rd_lit(4'd8, 8'h01, "R8 count cleared");
    rd_lit(4'd4, 8'h05, "R8 address independent");

    // R7 rollover in the same cycle as wrap clear
    cyc(4'd8, 1, 8'h02, 1);
    rd_lit(4'd8, 8'h02, "R7 set wins over clear");
    cyc(4'd8, 1, 8'h02, 0);

    // R9 count byte load with strobe
    cyc(4'd1, 1, 8'h3C, 1);
    rd_lit(4'd0, 8'hFF, "R9 count lsb kept");
    rd_lit(4'd1, 8'h3C, "R9 count byte loaded");
    rd_lit(4'd4, 8'h07, "R9 address stepped");
    // R9 address byte load with strobe
    cyc(4'd5, 1, 8'hAA, 1);
    rd_lit(4'd4, 8'h07, "R9 address not stepped");
    rd_lit(4'd5, 8'hAA, "R9 address byte loaded");
    rd_lit(4'd0, 8'hFE, "R3 count stepped");

    // R4 full address rollover
    for (int k = 4; k < 8; k++) cyc(4'(k), 1, 8'hFF, 0);
    cyc(4'd0, 0, 8'h00, 1);
    rd_lit(4'd4, 8'h00, "R4 addr wrap lsb");
    rd_lit(4'd7, 8'h00, "R4 addr wrap msb");

    // R10 unmapped offsets
    cyc(4'd3, 1, 8'h77, 0);
    cyc(4'd12, 1, 8'hFF, 0);
    rd_lit(4'd3, 8'h00, "R10 offset 3 reads zero");
    rd_lit(4'd12, 8'h00, "R10 offset 12 reads zero");
    rd_lit(4'd0, 8'hFD, "R10 count untouched");
    rd_lit(4'd8, 8'h00, "R10 flags untouched");

    // pseudo-random completion stream with rotating reads
    cyc(4'd0, 1, 8'h40, 0); cyc(4'd1, 1, 8'h00, 0); cyc(4'd2, 1, 8'h00, 0);
    for (int n = 0; n < 400; n++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      cyc(4'(n % 9), 0, 8'h00, lcg[16], "R3 stream readback");
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule